// File: doc/BRIEF.md
# Frame-Clocked Serial Configuration Loader

This block holds a small 5-bit format register that sets up a serial audio receiver. It has reset defaults, so the receiver works without any write. To change the format, a host sends an 8-bit code, one bit per frame. Each bit is captured when the frame clock falls. The first three bits are a guard pattern that must match before anything is written. The last five bits become the new format fields.

A write is refused in four cases:
- the guard pattern is wrong;
- the code is the one reserved all-zero-payload pattern;
- the separate serial data line drops low during the sequence;
- the receiver has been switched to its externally clocked mode.

The frame clock, the code-bit line and the data line are asynchronous, so each is brought into the system clock through a multi-flop synchroniser. An accepted write raises a single-cycle update pulse. The field outputs show the new values in that same cycle.

The block has no data stream. Every pin is a plain control or status level, so there is no handshake or back-pressure.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the fields read ratio_sel_o=2'b10, right_just_o=0, i2s_en_o=0, word16_o=0, cfg_update_o=0, and the block is unlocked.
- R2: A code bit is taken from code_bit_i only on a falling edge of frame_clk_i. Changes of code_bit_i while frame_clk_i is static, and rising edges of frame_clk_i, sample nothing. The first bit sent is B1 and the eighth is B8.
- R3: A code is committed only when B1,B2,B3 = 0,1,0. With any other guard pattern the fields and cfg_update_o stay unchanged.
- R4: The code B1..B8 = 0,1,0,0,0,0,0,0 is rejected. A code that differs from it in any payload bit, such as 0,1,0,0,0,0,0,1, is accepted.
- R5: sdata_i must be high at all eight falling edges of one code. If it is low at any of them, the code is discarded.
- R6: Once ext_mode_i is seen high, the block locks. It then ignores all codes until the next reset, even if ext_mode_i returns low.
- R7: On a commit the fields take their new values from the code as follows:

  | Field | Code bits |
  |---|---|
  | ratio_sel_o | {B4,B5} |
  | right_just_o | B6 |
  | i2s_en_o | B7 |
  | word16_o | B8 |

  cfg_update_o is high for exactly that one system clock cycle.
- R8: The bit counter wraps after each eighth bit, whether or not the code was accepted. Codes sent back to back are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk_i | input | 1 | Frame clock; a code bit is taken on each falling edge |
| code_bit_i | input | 1 | Line carrying the configuration code, first bit first |
| sdata_i | input | 1 | Serial data line; must stay high during a write |
| ext_mode_i | input | 1 | High once the receiver runs on an external bit clock |
| ratio_sel_o | output | 2 | Bit-clock to frame ratio select {B4,B5} |
| right_just_o | output | 1 | Right-justified data when high (B6) |
| i2s_en_o | output | 1 | I2S framing enabled when high (B7) |
| word16_o | output | 1 | 16-bit words when high, 18-bit when low (B8) |
| cfg_update_o | output | 1 | One-cycle pulse when a new code is committed |

## Verification
The assertions check the following on every cycle:
- the fields change only in a cycle that carries the update pulse;
- the pulse never lasts two cycles;
- the lock never releases, and the fields stay frozen while it holds;
- the bit counter moves only on a detected frame-clock fall;
- such falls are never back to back.

The bench scenarios are needed to show the rest:
- which codes are actually accepted;
- the exact field mapping;
- the blacklisted code and its one-bit neighbour;
- a data line dropped low mid-sequence;
- the sticky lock after ext_mode_i falls again;
- the return to defaults after a second reset.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int CODE_W   = 8;
  localparam int GUARD_W  = 3;
  localparam int FIELD_W  = CODE_W - GUARD_W;
  localparam int CNT_W    = $clog2(CODE_W);

  localparam logic [GUARD_W-1:0] GUARD_OK = 3'b010;
  localparam logic [CODE_W-1:0]  CODE_BAD = 8'b0100_0000;

  typedef struct packed {
    logic [1:0] ratio;
    logic       rjust;
    logic       i2s;
    logic       w16;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{ratio: 2'b10, rjust: 1'b0, i2s: 1'b0, w16: 1'b0};
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_s,
  input  logic              bit_s,
  input  logic              sdata_s,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              line_ok_o
);
  logic             frame_prev_q;
  logic             fall;
  logic [CNT_W-1:0] cnt_q;
  logic [CODE_W-2:0] sr_q;
  logic             ok_q;
  logic             ok_now;
  logic             last_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_prev_q <= 1'b0;
    else        frame_prev_q <= frame_s;

  assign fall     = frame_prev_q & ~frame_s;
  assign last_bit = (cnt_q == CNT_W'(CODE_W-1));
  assign ok_now   = ((cnt_q == '0) ? 1'b1 : ok_q) & sdata_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      ok_q  <= 1'b1;
    end else if (fall) begin
      sr_q  <= {sr_q[CODE_W-3:0], bit_s};
      ok_q  <= ok_now;
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  assign done_o    = fall & last_bit;
  assign code_o    = {sr_q, bit_s};
  assign line_ok_o = ok_now;

  // R2
  cnt_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(cnt_q));
  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/cfgl_commit.sv
module cfgl_commit
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              line_ok_i,
  input  logic              ext_mode_i,
  output cfg_t              cfg_o,
  output logic              upd_o
);
  logic lock_q;
  logic guard_hit;
  logic blacklisted;
  logic accept;
  cfg_t cfg_q;
  logic upd_q;

  assign guard_hit   = (code_i[CODE_W-1 -: GUARD_W] == GUARD_OK);
  assign blacklisted = (code_i == CODE_BAD);
  assign accept      = done_i & guard_hit & ~blacklisted & line_ok_i & ~lock_q & ~ext_mode_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_q | ext_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      upd_q <= 1'b0;
    end else begin
      upd_q <= accept;
      if (accept) cfg_q <= cfg_t'(code_i[FIELD_W-1:0]);
    end
  end

  assign cfg_o = cfg_q;
  assign upd_o = upd_q;

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R6
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(cfg_q) && !upd_q));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk_i,
  input  logic       code_bit_i,
  input  logic       sdata_i,
  input  logic       ext_mode_i,
  output logic [1:0] ratio_sel_o,
  output logic       right_just_o,
  output logic       i2s_en_o,
  output logic       word16_o,
  output logic       cfg_update_o
);
  logic [2:0]        sync_v;
  logic              done;
  logic [CODE_W-1:0] code;
  logic              line_ok;
  cfg_t              cfg;
  logic              upd;

  cfgl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({frame_clk_i, code_bit_i, sdata_i}),
    .sync_o  (sync_v)
  );

  cfgl_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_s   (sync_v[2]),
    .bit_s     (sync_v[1]),
    .sdata_s   (sync_v[0]),
    .done_o    (done),
    .code_o    (code),
    .line_ok_o (line_ok)
  );

  cfgl_commit u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .code_i     (code),
    .line_ok_i  (line_ok),
    .ext_mode_i (ext_mode_i),
    .cfg_o      (cfg),
    .upd_o      (upd)
  );

  assign ratio_sel_o  = cfg.ratio;
  assign right_just_o = cfg.rjust;
  assign i2s_en_o     = cfg.i2s;
  assign word16_o     = cfg.w16;
  assign cfg_update_o = upd;

  // R3 R4 R5
  change_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ratio_sel_o, right_just_o, i2s_en_o, word16_o}) |-> cfg_update_o);
  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update_o |=> !cfg_update_o);
endmodule

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk_i = 1'b1, code_bit_i = 1'b1, sdata_i = 1'b1, ext_mode_i = 1'b0;
  logic [1:0] ratio_sel_o;
  logic right_just_o, i2s_en_o, word16_o, cfg_update_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int exp_pulses = 0;
  logic [4:0] model = 5'b10000;
  logic [4:0] exp_q [$];
  logic prev_pulse = 1'b0;

  always #4 clk = ~clk;

  serial_cfg_loader u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk_i), .code_bit_i(code_bit_i),
    .sdata_i(sdata_i), .ext_mode_i(ext_mode_i), .ratio_sel_o(ratio_sel_o),
    .right_just_o(right_just_o), .i2s_en_o(i2s_en_o), .word16_o(word16_o),
    .cfg_update_o(cfg_update_o)
  );

  function automatic logic [4:0] fields();
    return {ratio_sel_o, right_just_o, i2s_en_o, word16_o};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each update pulse
  always @(negedge clk) begin
    if (!rst_n) prev_pulse <= 1'b0;
    else begin
      if (cfg_update_o) begin
        pulses++;
        check(!prev_pulse, "R7 pulse width", 8'(prev_pulse), 8'd0);
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected update", 8'(fields()), 8'd0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(fields() == e, "R7 field mapping", 8'(fields()), 8'(e));
        end
      end
      prev_pulse <= cfg_update_o;
    end
  end

  task automatic send_code(input logic [7:0] code, input logic [7:0] sd_mask, input logic commit, input string tag);
    if (commit) begin
      exp_q.push_back(code[4:0]);
      exp_pulses++;
      model = code[4:0];
    end
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      frame_clk_i = 1'b1; code_bit_i = code[i]; sdata_i = sd_mask[i];
      repeat (4) @(negedge clk);
      frame_clk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    frame_clk_i = 1'b1; sdata_i = 1'b1;
    repeat (10) @(negedge clk);
    check(fields() == model, tag, 8'(fields()), 8'(model));
    check(pulses == exp_pulses, {tag, " pulse count"}, 8'(pulses), 8'(exp_pulses));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fields() == 5'b10000 && !cfg_update_o, "R1 reset defaults", 8'({fields(), cfg_update_o}), 8'b10_0000);
    // R3 R7 good code
    send_code(8'b010_11101, 8'hFF, 1'b1, "R3 good guard");
    // R3 bad guard
    send_code(8'b110_00000, 8'hFF, 1'b0, "R3 bad guard");
    send_code(8'b011_01110, 8'hFF, 1'b0, "R3 bad guard 011");
    // R4 blacklisted code and its neighbour
    send_code(8'b010_00000, 8'hFF, 1'b0, "R4 blacklisted");
    send_code(8'b010_00001, 8'hFF, 1'b1, "R4 neighbour accepted");
    // R5 data line low on one bit
    send_code(8'b010_11110, 8'b1110_1111, 1'b0, "R5 sdata low mid");
    send_code(8'b010_01010, 8'b0111_1111, 1'b0, "R5 sdata low first");
    // R8 back-to-back codes after rejects
    send_code(8'b010_00010, 8'hFF, 1'b1, "R8 independent code");
    send_code(8'b010_10100, 8'hFF, 1'b1, "R8 second code");
    // R2 code line toggling without a frame edge
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); code_bit_i = ~code_bit_i;
    end
    repeat (8) @(negedge clk);
    check(fields() == model, "R2 no edge no sample", 8'(fields()), 8'(model));
    send_code(8'b010_11001, 8'hFF, 1'b1, "R2 aligned after idle");
    // R6 lock
    @(negedge clk); ext_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    send_code(8'b010_00111, 8'hFF, 1'b0, "R6 locked write");
    ext_mode_i = 1'b0;
    send_code(8'b010_00110, 8'hFF, 1'b0, "R6 sticky lock");
    // R1 reset again restores defaults and unlocks
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model = 5'b10000;
    @(negedge clk);
    check(fields() == 5'b10000, "R1 defaults after reset", 8'(fields()), 8'b1_0000);
    send_code(8'b010_01111, 8'hFF, 1'b1, "R1 unlocked after reset");
    check(exp_q.size() == 0, "R7 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule